// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves bytes between system memory and the endpoint FIFOs of a USB device core. It has eight independent channels. The host CPU drives each channel through a small register bank: a start address, a byte count and a control word. Writing the control word with its enable bit set starts the channel. A transmit channel reads memory and pushes the bytes into the FIFO of its endpoint. A receive channel pops bytes from that FIFO and writes them to memory.

Only one channel uses the byte-wide memory port at a time. A round-robin arbiter among the running channels hands the port out one burst at a time. The burst length comes from a code in the control word, and a granted burst always finishes on the same channel.

While a channel runs, its address register advances and its count register falls, so software can read progress from either one. When a channel finishes, or when the memory port reports an error, the channel drops its enable bit and sets its bit in a shared pending byte. Reading that byte clears the bits that were returned. The interrupt line is high while any pending channel also has its interrupt enable set.

Top module: `dma_engine`

## Requirements
- R1: After reset, every channel register and the pending byte read zero, `irq` is low and `mem_req` is low.
- R2: Register map. The pending byte reads at 0x200. Channel n uses the window 0x200 + 16·n, with control at +0x4, address at +0x8 and count at +0xC. Control fields: bit 0 enable, bit 1 transmit (memory to FIFO), bit 2 continuous mode, bit 3 interrupt enable, bits 7:4 endpoint, bit 8 bus error (read only), bits 10:9 burst code. Control reads back as written, except that bit 8 reads zero after a write.
- R3: A read of 0x200 returns the pending byte, with bit n set for channel n. The bits it returned are cleared after the read.
- R4: `irq` is high exactly when some channel has its pending bit set and its interrupt-enable bit set.
- R5: On a transmit channel, each accepted memory beat reads the current address, and the byte read is pushed to the FIFO of the channel's endpoint. On a receive channel, each beat pops that FIFO and writes the byte to the current address. Every good beat adds one to the address and takes one from the count. No beat is requested while the endpoint FIFO is not ready.
- R6: In continuous mode (bit 2 = 1) a channel moves its whole count. In packet mode (bit 2 = 0) it moves min(count, PKT_BYTES) bytes. Either way, the count then reads back the bytes still remaining.
- R7: On completion the enable bit clears and the channel's pending bit sets. A channel started with a count of zero completes without requesting memory.
- R8: A beat that the memory port answers with an error moves no data. It sets control bit 8, clears the enable bit and sets the pending bit, and the address stays at the failing byte.
- R9: Writing zero to a channel's control, address and count stops the channel. It makes no further memory requests and sets no pending bit.
- R10: The burst codes 0, 1, 2 and 3 give 1, 4, 8 and 16 beats, cut short by the bytes remaining. Channels get bursts in round-robin order, and a burst is never interleaved with another channel's beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (clears the pending bits it reads) |
| cpu_addr | input | ADDR_W | Register byte address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, combinational from cpu_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write (receive), 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Beat accepted in this cycle |
| mem_err | input | 1 | Accepted beat failed |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| fifo_ep | output | EP_W | Endpoint selected for FIFO access |
| fifo_push | output | 1 | Push fifo_wdata into the selected endpoint FIFO |
| fifo_wdata | output | 8 | Byte to push |
| fifo_pop | output | 1 | Pop one byte from the selected endpoint FIFO |
| fifo_rdata | input | 8 | Head byte of the selected endpoint FIFO |
| fifo_space | input | 2**EP_W | Per endpoint: FIFO can take a byte |
| fifo_avail | input | 2**EP_W | Per endpoint: FIFO holds a byte |

## Verification
The assertions assume that `mem_ack` and `mem_err` mean something only while `mem_req` is high. They also assume that software does not rewrite a channel's control word in the same cycle as a memory error on that channel. The bench drives acknowledges at random but gives them effect only through the request handshake. It injects errors only at a chosen address and never writes control while a burst is failing. It changes FIFO readiness only for all endpoints at once, between register operations, so each completion can be predicted.

// File: rtl/dma_pkg.sv
package dma_pkg;
    // Channel control word, bit 10 down to bit 0
    typedef struct packed {
        logic [1:0] burst;
        logic       berr;
        logic [3:0] ep;
        logic       ien;
        logic       cont;
        logic       tx;
        logic       en;
    } ctrl_t;

    localparam logic [3:0] OFF_PEND = 4'h0;
    localparam logic [3:0] OFF_CTRL = 4'h4;
    localparam logic [3:0] OFF_ADDR = 4'h8;
    localparam logic [3:0] OFF_CNT  = 4'hC;

    function automatic logic [4:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            2'd3:    return 5'd16;
            default: return 5'd1;
        endcase
    endfunction
endpackage

// File: rtl/dma_rr.sv
module dma_rr #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic [W-1:0] pick,
    output logic         any
);
    logic [W-1:0] idx;

    always_comb begin
        pick = last;
        any  = 1'b0;
        idx  = '0;
        for (int i = 1; i <= N; i++) begin
            idx = W'((int'(last) + i) % N);
            if (!any && req[idx]) begin
                pick = idx;
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int CNT_W     = 17,
    parameter int PKT_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_addr,
    input  logic             wr_cnt,
    input  logic [31:0]      wdata,
    input  logic             beat,
    input  logic             beat_err,
    output ctrl_t            ctrl,
    output logic [31:0]      addr,
    output logic [CNT_W-1:0] cnt,
    output logic             want,
    output logic [4:0]       nbeats,
    output logic             fin
);
    logic [CNT_W-1:0] pkt_left;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] blen;

    always_comb begin
        want  = ctrl.en && (cnt != '0) && (ctrl.cont || pkt_left != '0);
        limit = (ctrl.cont || cnt < pkt_left) ? cnt : pkt_left;
        blen  = CNT_W'(burst_beats(ctrl.burst));
        nbeats = (limit < blen) ? limit[4:0] : blen[4:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            addr     <= '0;
            cnt      <= '0;
            pkt_left <= '0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (wr_ctrl) begin
                ctrl      <= ctrl_t'(wdata[10:0]);
                ctrl.berr <= 1'b0;
                pkt_left  <= CNT_W'(PKT_BYTES);
            end else if (beat_err) begin
                ctrl.en   <= 1'b0;
                ctrl.berr <= 1'b1;
                fin       <= 1'b1;
            end else if (ctrl.en && !want) begin
                ctrl.en <= 1'b0;
                fin     <= 1'b1;
            end else if (beat && !ctrl.cont) begin
                pkt_left <= pkt_left - 1'b1;
            end
            if (wr_addr)   addr <= wdata;
            else if (beat) addr <= addr + 32'd1;
            if (wr_cnt)    cnt <= wdata[CNT_W-1:0];
            else if (beat) cnt <= cnt - 1'b1;
        end
    end

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        beat && !wr_addr && !wr_cnt |=> (addr - $past(addr)) == 32'd1 && ($past(cnt) - cnt) == CNT_W'(1));
    // R6
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> cnt <= $past(cnt));
    // R8
    berr_chk: assert property (@(posedge clk) disable iff (rst)
        beat_err && !wr_ctrl |=> !ctrl.en && ctrl.berr && fin);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int ADDR_W    = 10,
    parameter int CNT_W     = 17,
    parameter int PKT_BYTES = 64,
    parameter int EP_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [31:0]          cpu_wdata,
    output logic [31:0]          cpu_rdata,
    output logic                 irq,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic [7:0]           mem_rdata,
    output logic [EP_W-1:0]      fifo_ep,
    output logic                 fifo_push,
    output logic [7:0]           fifo_wdata,
    output logic                 fifo_pop,
    input  logic [7:0]           fifo_rdata,
    input  logic [(1<<EP_W)-1:0] fifo_space,
    input  logic [(1<<EP_W)-1:0] fifo_avail
);
    localparam int CH_W = $clog2(NCH);

    ctrl_t            ctl   [NCH];
    logic [31:0]      caddr [NCH];
    logic [CNT_W-1:0] ccnt  [NCH];
    logic [4:0]       nb    [NCH];
    logic [NCH-1:0]   want, fin, ien, pend, clr;

    logic             owner_v;
    logic [CH_W-1:0]  owner, last, pick;
    logic [4:0]       beats_left;
    logic             any, in_win, rdy, good, bad;
    logic [CH_W-1:0]  sel_ch;
    logic [3:0]       sel_reg;

    // CPU decode
    assign sel_ch  = cpu_addr[4 +: CH_W];
    assign sel_reg = cpu_addr[3:0];
    assign in_win  = cpu_addr[ADDR_W-1] && (cpu_addr[ADDR_W-2:4+CH_W] == '0);

    // Owner's memory and FIFO beat
    assign rdy       = ctl[owner].tx ? fifo_space[ctl[owner].ep] : fifo_avail[ctl[owner].ep];
    assign mem_req   = owner_v && want[owner] && rdy;
    assign mem_we    = !ctl[owner].tx;
    assign mem_addr  = caddr[owner];
    assign mem_wdata = fifo_rdata;
    assign fifo_ep   = ctl[owner].ep;
    assign fifo_wdata = mem_rdata;
    assign good      = mem_req && mem_ack && !mem_err;
    assign bad       = mem_req && mem_ack && mem_err;
    assign fifo_push = good && ctl[owner].tx;
    assign fifo_pop  = good && !ctl[owner].tx;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_chan #(.CNT_W(CNT_W), .PKT_BYTES(PKT_BYTES)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (cpu_wr && in_win && sel_ch == CH_W'(i) && sel_reg == OFF_CTRL),
            .wr_addr  (cpu_wr && in_win && sel_ch == CH_W'(i) && sel_reg == OFF_ADDR),
            .wr_cnt   (cpu_wr && in_win && sel_ch == CH_W'(i) && sel_reg == OFF_CNT),
            .wdata    (cpu_wdata),
            .beat     (good && owner == CH_W'(i)),
            .beat_err (bad && owner == CH_W'(i)),
            .ctrl     (ctl[i]),
            .addr     (caddr[i]),
            .cnt      (ccnt[i]),
            .want     (want[i]),
            .nbeats   (nb[i]),
            .fin      (fin[i])
        );
        assign ien[i] = ctl[i].ien;
    end

    dma_rr #(.N(NCH)) u_rr (.req(want), .last(last), .pick(pick), .any(any));

    // Burst ownership
    always_ff @(posedge clk) begin
        if (rst) begin
            owner_v    <= 1'b0;
            owner      <= '0;
            last       <= CH_W'(NCH - 1);
            beats_left <= '0;
        end else if (!owner_v) begin
            if (any) begin
                owner_v    <= 1'b1;
                owner      <= pick;
                last       <= pick;
                beats_left <= nb[pick];
            end
        end else if (!want[owner] || bad) begin
            owner_v <= 1'b0;
        end else if (good) begin
            beats_left <= beats_left - 5'd1;
            if (beats_left == 5'd1) owner_v <= 1'b0;
        end
    end

    // Pending byte, clear on read
    assign clr = (cpu_rd && in_win && sel_ch == '0 && sel_reg == OFF_PEND) ? pend : '0;
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | fin;
    end
    assign irq = |(pend & ien);

    always_comb begin
        cpu_rdata = '0;
        if (in_win) begin
            case (sel_reg)
                OFF_PEND: if (sel_ch == '0) cpu_rdata = 32'(pend);
                OFF_CTRL: cpu_rdata = 32'(ctl[sel_ch]);
                OFF_ADDR: cpu_rdata = caddr[sel_ch];
                OFF_CNT:  cpu_rdata = 32'(ccnt[sel_ch]);
                default:  cpu_rdata = '0;
            endcase
        end
    end

    // R10
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        owner_v && want[owner] && !bad && !(good && beats_left == 5'd1)
        |=> owner_v && owner == $past(owner));
    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && in_win && sel_ch == '0 && sel_reg == OFF_PEND && fin == '0
        |=> (pend & $past(pend)) == '0);
    // R5
    fifo_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_we ? fifo_avail[fifo_ep] : fifo_space[fifo_ep]));
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
    localparam int PKT = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 0, cpu_rd = 0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        irq, mem_req, mem_we, mem_ack = 0, mem_err;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, fifo_wdata, fifo_rdata;
    logic [3:0]  fifo_ep;
    logic        fifo_push, fifo_pop;
    logic        fifo_ok = 1'b1;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic [7:0]  rx_seq = 8'h00;

    int nchk = 0, nfail = 0;
    int beats = 0, pushes = 0, pops = 0;
    int run = 0, switches = 0;
    logic [3:0] cur_r = '0;
    bit run_chk = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata  = memf(mem_addr);
    assign mem_err    = err_en && (mem_addr == err_addr);
    assign fifo_rdata = rx_seq;

    dma_engine dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .fifo_ep(fifo_ep), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
        .fifo_space({16{fifo_ok}}), .fifo_avail({16{fifo_ok}})
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) mem_ack <= ($urandom % 10) < 7;

    // Beat monitor
    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack && !mem_err) begin
            beats++;
            if (fifo_push) begin
                pushes++;
                check("R5 tx byte", {24'b0, fifo_wdata}, {24'b0, memf(mem_addr)});
            end
            if (fifo_pop) begin
                pops++;
                check("R5 rx byte", {24'b0, mem_wdata}, {24'b0, rx_seq});
                rx_seq = rx_seq + 8'd1;
            end
            if (mem_addr[15:12] != cur_r) begin
                if (run_chk && run % 4 != 0) check("R10 burst run", run, 0);
                if (run > 0) switches++;
                run = 0;
                cur_r = mem_addr[15:12];
            end
            run++;
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1 cpu_wr = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_rd = 1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(posedge clk); #1 cpu_rd = 0;
    endtask

    function automatic logic [9:0] creg(input int ch, input logic [3:0] off);
        return 10'h200 + 10'(ch << 4) + 10'(off);
    endfunction

    task automatic start(input int ch, input bit tx, input bit cont, input bit ie,
                         input logic [3:0] ep, input logic [1:0] bc,
                         input logic [31:0] a, input int n);
        wr(creg(ch, 4'h8), a);
        wr(creg(ch, 4'hC), n);
        wr(creg(ch, 4'h4), {21'b0, bc, 1'b0, ep, ie, cont, tx, 1'b1});
    endtask

    task automatic wait_done(input int ch);
        logic [31:0] d;
        for (int k = 0; k < 3000; k++) begin
            rd(creg(ch, 4'h4), d);
            if (!d[0]) return;
        end
        check("R7 channel hung", 1, 0);
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        rd(10'h200, d); check("R1 pending", d, 0);
        rd(creg(0, 4'h4), d); check("R1 ctrl", d, 0);
        rd(creg(7, 4'hC), d); check("R1 count", d, 0);
        check("R1 irq", irq, 0);
        check("R1 mem_req", mem_req, 0);

        // R2 control layout readback, enable off, bit 8 dropped
        wr(creg(6, 4'h4), 32'h0000_07FE);
        rd(creg(6, 4'h4), d); check("R2 ctrl readback", d, 32'h0000_06FE);
        wr(creg(6, 4'h4), 0);

        // R7 zero-count start
        beats = 0;
        start(2, 1, 1, 1, 4'd3, 2'd0, 32'h0000_3000, 0);
        wait_done(2);
        check("R7 no beats", beats, 0);
        check("R4 irq on zero-count", irq, 1);
        rd(creg(2, 4'h8), d); check("R7 addr unchanged", d, 32'h3000);
        rd(10'h200, d); check("R3 pending bit2", d, 32'h04);
        rd(10'h200, d); check("R3 cleared", d, 0);

        // Random transfers (R5, R6, R7, R4, R3)
        for (int it = 0; it < 24; it++) begin
            int ch, n, exp_b;
            bit tx, cont, ie;
            logic [1:0] bc;
            logic [31:0] a;
            ch = $urandom % 8; tx = $urandom % 2; cont = $urandom % 2;
            ie = $urandom % 2; bc = 2'($urandom % 4);
            n = 1 + ($urandom % 100);
            a = 32'h0001_0000 + ($urandom % 4096);
            exp_b = cont ? n : (n < PKT ? n : PKT);
            pushes = 0; pops = 0;
            start(ch, tx, cont, ie, 4'($urandom % 16), bc, a, n);
            wait_done(ch);
            check("R6 bytes moved", tx ? pushes : pops, exp_b);
            rd(creg(ch, 4'h8), d); check("R5 final addr", d, a + exp_b);
            rd(creg(ch, 4'hC), d); check("R6 remaining count", d, n - exp_b);
            check("R4 irq follows enable", irq, ie);
            rd(10'h200, d); check("R7 pending bit", d, 32'(1 << ch));
            check("R4 irq after clear", irq, 0);
        end

        // R8 bus error
        err_en = 1; err_addr = 32'h0000_5007;
        pushes = 0;
        start(5, 1, 1, 1, 4'd1, 2'd1, 32'h0000_5000, 20);
        wait_done(5);
        err_en = 0;
        rd(creg(5, 4'h4), d); check("R8 error flag and enable", {d[8], d[0]}, 32'b10);
        rd(creg(5, 4'h8), d); check("R8 addr at fault", d, 32'h5007);
        check("R8 bytes before fault", pushes, 7);
        rd(10'h200, d); check("R8 pending bit5", d, 32'h20);

        // R9 abort with FIFO stalled
        fifo_ok = 0; beats = 0;
        start(3, 0, 1, 1, 4'd2, 2'd2, 32'h0000_6000, 30);
        repeat (5) @(posedge clk);
        wr(creg(3, 4'h4), 0);
        wr(creg(3, 4'h8), 0);
        wr(creg(3, 4'hC), 0);
        fifo_ok = 1;
        repeat (40) @(posedge clk);
        check("R9 no beats after abort", beats, 0);
        rd(creg(3, 4'h4), d); check("R9 ctrl idle", d, 0);
        rd(10'h200, d); check("R9 no pending", d, 0);
        check("R9 irq low", irq, 0);

        // R10 two channels, 4-beat bursts, interleaved
        fifo_ok = 0; switches = 0; run = 0; cur_r = 4'h0; run_chk = 1;
        start(0, 1, 1, 0, 4'd4, 2'd1, 32'h0000_1000, 32);
        start(1, 1, 1, 0, 4'd5, 2'd1, 32'h0000_2000, 32);
        fifo_ok = 1;
        wait_done(0);
        wait_done(1);
        run_chk = 0;
        check("R10 round-robin interleave", switches >= 3, 1);
        rd(10'h200, d); check("R10 both pending", d, 32'h03);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule